// File: doc/BRIEF.md
# Polled Three-Wire Converter Reader

This block runs the host side of a serial link to a data converter whose port is clocked from outside. Chip select is held low for the whole session and no framing signal exists. A session starts with a one-cycle `start_i` pulse, which latches a configuration word. The reader then watches the converter's data line. While a conversion is running that line is high. When it drops, the reader knows a result is ready.

The reader then drives 32 serial clock pulses, which idle low. Each half-period lasts a set number of system-clock cycles. On every falling edge the reader puts out the next configuration bit, most significant first. On every rising edge it samples the data line. The first captured bit is the status bit. All captured bits are assembled most significant first. After the last falling edge the converter must raise its line to show that a new conversion has begun, and only then is the captured word taken as valid.

Two timers guard the session. One limits how long the line may stay high before the transfer. The other limits how long it may stay low after the transfer. Each timer ends the session with its own sticky flag. A `done_o` pulse marks the end of every session, whatever the outcome.

Top module: `conv_reader`

## Requirements
- R1: After reset, `conv_sclk_o`, `conv_din_o`, `busy_o`, `done_o`, `wait_timeout_o` and `return_err_o` are low and `result_o` is zero.
- R2: After a start, no serial clock pulse is produced while `conv_dout_i` is high. Clocking begins only once the line is seen low.
- R3: A session that reaches the transfer produces exactly 32 serial clock pulses. Each high phase and each low phase lasts `HALF_CYC` system cycles, and the clock is low outside the transfer.
- R4: The latched configuration word appears on `conv_din_o` most significant bit first. The first bit is presented before the first rising edge, and the line changes only on falling edges, so it is stable at every rising edge.
- R5: The data line is sampled on each rising serial clock edge. The 32 samples form `result_o` with the first sample (the status bit) in bit 31.
- R6: When the line is seen high after the 32nd falling edge, `done_o` pulses for one cycle and `result_o` takes the captured word in that same cycle. The `done_o` pulse comes max(P,1) + 64·HALF_CYC + 1 + D cycles after the start edge. P is the number of cycles the line stays high after start, and D is the number of cycles it stays low after the last falling edge.
- R7: If the line stays low for `RET_LIMIT` cycles after the 32nd falling edge, `return_err_o` is set and `done_o` pulses. `result_o` keeps its previous value.
- R8: If the line stays high for `WAIT_LIMIT` cycles after start, `wait_timeout_o` is set and `done_o` pulses `WAIT_LIMIT` cycles after the start edge. No serial clock pulse is produced.
- R9: A start pulse while `busy_o` is high is ignored. The running session keeps its timing and result, and no new session follows.
- R10: `wait_timeout_o` and `return_err_o` hold their value until the next accepted start, which clears them. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a session |
| cfg_word_i | input | WORD_W | Configuration word, latched on an accepted start |
| conv_dout_i | input | 1 | Converter data line: status bit, then result bits |
| conv_sclk_o | output | 1 | Serial clock to the converter, idle low |
| conv_din_o | output | 1 | Configuration bit to the converter |
| busy_o | output | 1 | High from an accepted start until the session ends |
| done_o | output | 1 | One-cycle pulse at the end of each session |
| result_o | output | WORD_W | Last word that was confirmed by the line returning high |
| wait_timeout_o | output | 1 | Sticky flag: the line stayed high too long before the transfer |
| return_err_o | output | 1 | Sticky flag: the line did not return high after the transfer |

## Verification
Each session has a fixed timing. `done_o` is due max(P,1) + 64·HALF_CYC + 1 + D cycles after the start edge. On a missing return it is due max(P,1) + 64·HALF_CYC + RET_LIMIT cycles after that edge, and on a wait timeout exactly WAIT_LIMIT cycles after it. The bench counts falling system-clock edges from the start and compares the count at which `done_o` is first seen high against these formulas. Results, flags and `busy_o` are therefore read half a cycle after the edge that updated them. The converter model changes its data line one time unit after each serial clock fall, which keeps the line stable well before the next rising edge that samples it.

// File: rtl/conv_reader_pkg.sv
package conv_reader_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_WAIT  = 2'd1,
    RD_SHIFT = 2'd2,
    RD_CHECK = 2'd3
  } rd_state_e;

endpackage

// File: rtl/rdr_rst_sync.sv
module rdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rdr_sclk_gen.sv
module rdr_sclk_gen #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  logic [HC_W-1:0] hc_q, hc_d;
  logic            sclk_q, sclk_d;
  logic            phase_end;

  assign phase_end = run_i && (hc_q == HC_LAST);
  assign rise_o    = phase_end && !sclk_q;
  assign fall_o    = phase_end && sclk_q;

  always_comb begin
    hc_d   = hc_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      hc_d   = '0;
      sclk_d = 1'b0;
    end else if (phase_end) begin
      hc_d   = '0;
      sclk_d = !sclk_q;
    end else begin
      hc_d   = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      hc_q   <= hc_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;

  // R3: clock is parked low whenever the transfer is not running
  assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_q);
endmodule

// File: rtl/rdr_word_shifter.sv
module rdr_word_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              line_i,
  output logic              tx_bit_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              last_shift_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign last_shift_o = shift_i && (cnt_q == CNT_LAST);

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    cnt_d = cnt_q;
    if (load_i) begin
      tx_d  = load_word_i;
      cnt_d = '0;
    end else begin
      if (capture_i) rx_d = {rx_q[WORD_W-2:0], line_i};
      if (shift_i) begin
        tx_d  = {tx_q[WORD_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      cnt_q <= cnt_d;
    end
  end

  assign tx_bit_o  = tx_q[WORD_W-1];
  assign rx_word_o = rx_q;

  // R3: never more shifts than word bits
  assert_shift_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R4: capture and shift never fall in the same cycle
  assert_edge_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture_i && shift_i));
endmodule

// File: rtl/rdr_span_timer.sv
module rdr_span_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire_o = inc_i && (cnt_q == (limit_i - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: count never passes the active limit
  assert_span_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i);
endmodule

// File: rtl/conv_reader.sv
module conv_reader
  import conv_reader_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned HALF_CYC   = 2,
  parameter int unsigned WAIT_LIMIT = 4096,
  parameter int unsigned RET_LIMIT  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic              conv_dout_i,
  output logic              conv_sclk_o,
  output logic              conv_din_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic              wait_timeout_o,
  output logic              return_err_o
);
  localparam int unsigned MAX_LIM = (WAIT_LIMIT > RET_LIMIT) ? WAIT_LIMIT : RET_LIMIT;
  localparam int unsigned TMR_W   = $clog2(MAX_LIM + 1);
  localparam logic [TMR_W-1:0] WAIT_LIM_V = TMR_W'(WAIT_LIMIT);
  localparam logic [TMR_W-1:0] RET_LIM_V  = TMR_W'(RET_LIMIT);

  logic rst_sync_n;

  rd_state_e         state_q, state_d;
  logic              done_q, done_d;
  logic              tmo_q, tmo_d;
  logic              err_q, err_d;
  logic [WORD_W-1:0] result_q, result_d;

  logic              load_en;
  logic              sclk_rise, sclk_fall, sclk_run;
  logic              last_shift;
  logic [WORD_W-1:0] rx_word;
  logic              tmr_inc, tmr_clr, tmr_expire;
  logic [TMR_W-1:0]  tmr_limit;

  rdr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign sclk_run = (state_q == RD_SHIFT);

  rdr_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (sclk_run),
    .sclk_o (conv_sclk_o),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  rdr_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load_i       (load_en),
    .load_word_i  (cfg_word_i),
    .capture_i    (sclk_rise),
    .shift_i      (sclk_fall),
    .line_i       (conv_dout_i),
    .tx_bit_o     (conv_din_o),
    .rx_word_o    (rx_word),
    .last_shift_o (last_shift)
  );

  assign tmr_limit = (state_q == RD_WAIT) ? WAIT_LIM_V : RET_LIM_V;
  assign tmr_inc   = ((state_q == RD_WAIT)  &&  conv_dout_i) ||
                     ((state_q == RD_CHECK) && !conv_dout_i);
  assign tmr_clr   = (state_d != state_q);

  rdr_span_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (tmr_clr),
    .inc_i    (tmr_inc),
    .limit_i  (tmr_limit),
    .expire_o (tmr_expire)
  );

  assign load_en = (state_q == RD_IDLE) && start_i;

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    tmo_d    = tmo_q;
    err_d    = err_q;
    result_d = result_q;
    unique case (state_q)
      RD_IDLE: begin
        if (start_i) begin
          state_d = RD_WAIT;
          tmo_d   = 1'b0;
          err_d   = 1'b0;
        end
      end
      RD_WAIT: begin
        if (!conv_dout_i) begin
          state_d = RD_SHIFT;
        end else if (tmr_expire) begin
          state_d = RD_IDLE;
          tmo_d   = 1'b1;
          done_d  = 1'b1;
        end
      end
      RD_SHIFT: begin
        if (last_shift) state_d = RD_CHECK;
      end
      RD_CHECK: begin
        if (conv_dout_i) begin
          state_d  = RD_IDLE;
          result_d = rx_word;
          done_d   = 1'b1;
        end else if (tmr_expire) begin
          state_d = RD_IDLE;
          err_d   = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= RD_IDLE;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      err_q    <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      tmo_q    <= tmo_d;
      err_q    <= err_d;
      result_q <= result_d;
    end
  end

  assign busy_o         = (state_q != RD_IDLE);
  assign done_o         = done_q;
  assign result_o       = result_q;
  assign wait_timeout_o = tmo_q;
  assign return_err_o   = err_q;

  // R2: no clocking while waiting on the status bit
  assert_no_sclk_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == RD_WAIT) |-> !conv_sclk_o);
  // R4: configuration line holds through each high phase
  assert_din_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (conv_sclk_o && $past(conv_sclk_o)) |-> $stable(conv_din_o));
  // R6: done lasts one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q);
  // R6: result only moves together with done
  assert_result_with_done_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_q |-> $stable(result_q));
  // R10: the two error flags never coexist
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({tmo_q, err_q}));
endmodule

// File: tb/conv_reader_tb_top.sv
module conv_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 2;
  localparam int WL = 24;
  localparam int RL = 6;
  localparam int NV = 5;

  localparam logic [31:0] V_CFG [NV] = '{32'hA5C3_0F81, 32'h8000_0001, 32'hFFFF_0000, 32'h1234_5678, 32'h0F0F_F0F0};
  localparam logic [31:0] V_WRD [NV] = '{32'h0123_4567, 32'h7FFF_FFFF, 32'h0000_0001, 32'h5A5A_A5A5, 32'h2AAA_AAAB};
  localparam int          V_P   [NV] = '{0, 3, WL, 1, 10};
  localparam int          V_D   [NV] = '{0, 2, RL-1, 0, 1};

  logic        clk, rst_n, start_i, conv_dout_i;
  logic [31:0] cfg_word_i;
  logic        conv_sclk_o, conv_din_o, busy_o, done_o, wait_timeout_o, return_err_o;
  logic [31:0] result_o;

  int          n_checks, n_fail;
  int          pulses;
  logic [31:0] cap_cfg;
  bit          finished;

  conv_reader #(.WORD_W(32), .HALF_CYC(H), .WAIT_LIMIT(WL), .RET_LIMIT(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_word_i(cfg_word_i),
    .conv_dout_i(conv_dout_i), .conv_sclk_o(conv_sclk_o), .conv_din_o(conv_din_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .wait_timeout_o(wait_timeout_o), .return_err_o(return_err_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge conv_sclk_o) begin
    pulses  = pulses + 1;
    cap_cfg = {cap_cfg[30:0], conv_din_o};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // drives one session; P = cycles line stays high after start, D = cycles low after last fall
  task automatic run_session(input logic [31:0] cfg, input logic [31:0] word,
                             input int p, input int d, input int glitch_at,
                             input bit no_conv, output int lat);
    @(negedge clk);
    cfg_word_i  = cfg;
    start_i     = 1'b1;
    conv_dout_i = (p > 0 || no_conv);
    pulses      = 0;
    cap_cfg     = '0;
    lat         = 0;
    fork
      begin
        if (!no_conv) begin
          if (p > 0) begin repeat (p) @(posedge clk); #1 conv_dout_i = 1'b0; end
          for (int k = 1; k <= 32; k++) begin
            @(negedge conv_sclk_o);
            #1;
            if (k < 32) conv_dout_i = word[31-k];
            else if (d == 0) conv_dout_i = 1'b1;
            else begin
              conv_dout_i = 1'b0;
              repeat (d) @(posedge clk);
              #1 conv_dout_i = 1'b1;
            end
          end
        end
      end
      begin
        do begin
          @(negedge clk);
          lat++;
          if (lat == 1) start_i = 1'b0;
          if (glitch_at > 0 && lat == glitch_at) start_i = 1'b1;
          if (glitch_at > 0 && lat == glitch_at + 1) start_i = 1'b0;
        end while (!done_o && lat < 2000);
      end
    join
  endtask

  function automatic int norm_lat(input int p, input int d);
    return ((p > 1) ? p : 1) + 64*H + 1 + d + 1;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin : main
    int lat;
    logic [31:0] prev_res;
    n_checks = 0; n_fail = 0; finished = 0;
    pulses = 0; cap_cfg = '0;
    rst_n = 1'b0; start_i = 1'b0; cfg_word_i = '0; conv_dout_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(conv_sclk_o == 0 && conv_din_o == 0, "R1", "serial lines", {conv_sclk_o, conv_din_o}, 0);
    check(!busy_o && !done_o, "R1", "busy/done", {busy_o, done_o}, 0);
    check(!wait_timeout_o && !return_err_o, "R1", "flags", {wait_timeout_o, return_err_o}, 0);
    check(result_o == 0, "R1", "result", result_o, 0);

    // table of normal sessions: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      run_session(V_CFG[v], V_WRD[v], V_P[v], V_D[v], 0, 0, lat);
      check(lat == norm_lat(V_P[v], V_D[v]), "R6", "done latency", lat, norm_lat(V_P[v], V_D[v]));
      check(result_o == V_WRD[v], "R5", "result word", result_o, V_WRD[v]);
      check(cap_cfg == V_CFG[v], "R4", "config bits at rises", cap_cfg, V_CFG[v]);
      check(pulses == 32, "R3", "pulse count", pulses, 32);
      check(!wait_timeout_o && !return_err_o, "R10", "flags clear", {wait_timeout_o, return_err_o}, 0);
      @(negedge clk);
      check(!done_o && !conv_sclk_o && !busy_o, "R6", "done single + idle", {done_o, conv_sclk_o, busy_o}, 0);
    end

    // R8 wait timeout, R2 no pulses
    prev_res = result_o;
    run_session(32'hDEAD_BEEF, 32'h0, 0, 0, 0, 1, lat);
    check(lat == WL + 1, "R8", "timeout latency", lat, WL + 1);
    check(wait_timeout_o && !return_err_o, "R8", "timeout flag", {wait_timeout_o, return_err_o}, 2);
    check(pulses == 0, "R2", "no pulses while line high", pulses, 0);
    check(result_o == prev_res, "R8", "result kept", result_o, prev_res);
    repeat (5) @(negedge clk);
    check(wait_timeout_o, "R10", "timeout flag held", wait_timeout_o, 1);

    // R10 next start clears flag
    run_session(32'h0000_00FF, 32'h3C3C_0F0F, 2, 0, 0, 0, lat);
    check(!wait_timeout_o, "R10", "flag cleared by start", wait_timeout_o, 0);
    check(result_o == 32'h3C3C_0F0F, "R5", "result after timeout", result_o, 32'h3C3C_0F0F);

    // R7 line never returns in time
    prev_res = result_o;
    run_session(32'h5555_AAAA, 32'h0BAD_F00D, 1, RL + 3, 0, 0, lat);
    check(lat == 1 + 64*H + RL + 1, "R7", "error latency", lat, 1 + 64*H + RL + 1);
    check(return_err_o && !wait_timeout_o, "R7", "error flag", {return_err_o, wait_timeout_o}, 2);
    check(result_o == prev_res, "R7", "result kept", result_o, prev_res);
    repeat (6) @(negedge clk);

    // R9 start during busy ignored
    run_session(32'hC001_D00D, 32'h1357_9BDF, 4, 1, 40, 0, lat);
    check(lat == norm_lat(4, 1), "R9", "latency with stray start", lat, norm_lat(4, 1));
    check(result_o == 32'h1357_9BDF, "R9", "result with stray start", result_o, 32'h1357_9BDF);
    check(!return_err_o, "R10", "error flag cleared", return_err_o, 0);
    repeat (3) @(negedge clk);
    check(!busy_o && pulses == 32, "R9", "no new session", {busy_o, pulses[7:0]}, 32);

    finished = 1;
    summary();
    $finish;
  end
endmodule